// File: doc/BRIEF.md
# Passive Serial Configuration Host

This block loads a bitstream into a downstream programmable device over a one-wire passive serial link. It holds the target in reset through an active-low request line and releases that line to begin a load. It then waits for the target's open-drain status line to read high. After that it takes bytes from a ready/valid stream and sends each one bit by bit on a serial data pin, with a data clock that it generates itself.

Once the last byte has gone out, the host watches the target's done line. When that line rises, the host sends a fixed number of extra clocks for the target's start-up and then reports success. If the status line falls during loading, if the status line never comes up, or if done never arrives, the host stops the data clock, holds the target in reset and reports a failure code. A failed or finished host does nothing further until it is given an explicit start command. The status and done inputs pass through synchronizers before the sequencer sees them.

Top module: `ps_cfg_host`

## Requirements
- R1: After reset the request line is low, the data clock is low, and ready, busy, done and fail all read 0.
- R2: When `start` is accepted in the idle, done or failed state, the request line is low for exactly `REQ_LOW_CYC` clock cycles and then rises.
- R3: No data clock pulse occurs and `s_ready` stays low until the status line has read high after the request was released. If the status line does not come up within `REL_TMO_CYC` cycles of that release, the host fails with `fail_code` = 3.
- R4: While running, `ser_clk` has a period of `CLK_DIV` system clocks and is high for `CLK_DIV/2` of them. Between bytes and whenever the host is not sending, it rests low.
- R5: Each byte goes out least-significant bit first. A bit changes only on a falling data-clock edge or while the clock rests low, so it is stable across every rising edge.
- R6: `s_ready` is high only while the host is waiting for a byte with the clock low. Each accepted byte produces exactly 8 rising data-clock edges before the next byte is accepted.
- R7: Once the done line reads high, the host stops sending data at the next bit boundary. It then gives exactly `INIT_CLKS` further rising edges, and only after that raises `cfg_done`, keeping the request line high.
- R8: If the status line reads low while the host waits for a byte, sends data or waits for done, the host reaches the failed state 3 cycles after the pin falls. In that state `ser_clk` and `s_ready` are low, the request line is low and `fail_code` = 1. A status drop wins over a done rise seen in the same cycle.
- R9: If done has not been seen `DONE_TMO_CYC` cycles after the falling edge that ends the last byte (`s_last`), the host fails with `fail_code` = 2.
- R10: The failed state never ends by itself. Only `start` leaves it, and `start` runs the full sequence again from the request pulse.
- R11: `start` has no effect while a load is in progress. The request line stays high and the byte stream continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin or restart a load (single-cycle pulse) |
| s_data | input | BYTE_W | Stream byte to send |
| s_valid | input | 1 | Stream byte valid |
| s_last | input | 1 | Marks the final byte of the bitstream |
| s_ready | output | 1 | Host accepts a byte this cycle |
| cfg_req_n | output | 1 | Active-low configuration request to the target |
| stat_n | input | 1 | Target status line, low while the target is in reset or in error |
| done_in | input | 1 | Target done line |
| ser_clk | output | 1 | Generated data clock |
| ser_data | output | 1 | Serial data, sampled by the target on rising `ser_clk` |
| busy | output | 1 | A load sequence is in progress |
| cfg_done | output | 1 | Load finished successfully |
| cfg_fail | output | 1 | Load failed |
| fail_code | output | 2 | 0 none, 1 status dropped, 2 done timeout, 3 status release timeout |

## Verification
The status line falling and the done line rising can reach the sequencer in the same cycle, and both pass through synchronizers of equal depth. The bench therefore changes both pins on the same clock phase in the middle of a byte. It expects the status error to win: failure code 1, no done flag, and a stopped clock. In a second collision the bench pulses `start` while bytes are streaming. It judges by the request line staying high and by all 256 swept byte values reaching the modelled target intact, LSB first.

// File: rtl/ps_cfg_pkg.sv
package ps_cfg_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_REQ,
        ST_WREL,
        ST_LOAD,
        ST_SHIFT,
        ST_WDONE,
        ST_INIT,
        ST_DONE,
        ST_ERR
    } cfg_state_e;

    typedef enum logic [1:0] {
        FC_NONE     = 2'd0,
        FC_STAT     = 2'd1,
        FC_DONE_TMO = 2'd2,
        FC_REL_TMO  = 2'd3
    } fail_code_e;

    // Synchronized view of the target's two sense lines
    typedef struct packed {
        logic done;
        logic stat_ok;
    } tgt_sense_t;

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // States in which the data clock toggles
    function automatic logic clk_running(input cfg_state_e s);
        return (s == ST_SHIFT) || (s == ST_INIT);
    endfunction

    // States in which a falling status line is a load error
    function automatic logic stat_watched(input cfg_state_e s);
        return (s == ST_LOAD) || (s == ST_SHIFT) || (s == ST_WDONE);
    endfunction

    // States in which the target is held in reset
    function automatic logic holds_reset(input cfg_state_e s);
        return (s == ST_IDLE) || (s == ST_REQ) || (s == ST_ERR);
    endfunction

    function automatic logic accepts_start(input cfg_state_e s);
        return (s == ST_IDLE) || (s == ST_DONE) || (s == ST_ERR);
    endfunction

endpackage

// File: rtl/ps_sync.sv
module ps_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b0;
                else     chain[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b0;
                else     chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ps_clkgen.sv
module ps_clkgen #(
    parameter int unsigned DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run_now,
    input  logic run_next,
    output logic sclk,
    output logic fall_tick
);
    localparam int unsigned HALF = DIV / 2;
    localparam int unsigned CW   = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] RISE_AT = CW'(HALF - 1);
    localparam logic [CW-1:0] FALL_AT = CW'(DIV - 1);

    logic [CW-1:0] phase;

    // Cleared from the sequencer's next state so a stop never leaves a runt high pulse
    always_ff @(posedge clk) begin
        if (rst || !run_next) begin
            phase <= '0;
            sclk  <= 1'b0;
        end else if (run_now) begin
            if (phase == FALL_AT) begin
                phase <= '0;
                sclk  <= 1'b0;
            end else begin
                phase <= phase + 1'b1;
                if (phase == RISE_AT) sclk <= 1'b1;
            end
        end
    end

    assign fall_tick = run_now && (phase == FALL_AT);
endmodule

// File: rtl/ps_shifter.sv
module ps_shifter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         shift,
    output logic         bit_o,
    output logic         last_o
);
    localparam int unsigned BW = (W > 2) ? $clog2(W) : 1;
    localparam logic [BW-1:0] LAST_IDX = BW'(W - 1);

    logic [W-1:0]  sreg;
    logic [BW-1:0] bcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg <= '0;
            bcnt <= '0;
        end else if (load) begin
            sreg <= din;
            bcnt <= '0;
        end else if (shift) begin
            sreg <= {1'b0, sreg[W-1:1]};
            bcnt <= bcnt + 1'b1;
        end
    end

    assign bit_o  = sreg[0];
    assign last_o = (bcnt == LAST_IDX);
endmodule

// File: rtl/ps_seq.sv
module ps_seq
    import ps_cfg_pkg::*;
#(
    parameter int unsigned REQ_LOW_CYC  = 16,
    parameter int unsigned REL_TMO_CYC  = 4096,
    parameter int unsigned DONE_TMO_CYC = 65536,
    parameter int unsigned INIT_CLKS    = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  tgt_sense_t sense,
    input  logic       fall_tick,
    input  logic       s_valid,
    input  logic       s_last,
    input  logic       last_bit,
    output cfg_state_e state_q,
    output logic       run_now,
    output logic       run_next,
    output logic       load,
    output logic       shift,
    output logic       s_ready,
    output fail_code_e err_q
);
    localparam int unsigned TMAX = umax(umax(REQ_LOW_CYC, REL_TMO_CYC),
                                        umax(DONE_TMO_CYC, INIT_CLKS));
    localparam int unsigned TW = $clog2(TMAX + 1);
    localparam logic [TW-1:0] REQ_END  = TW'(REQ_LOW_CYC - 1);
    localparam logic [TW-1:0] REL_END  = TW'(REL_TMO_CYC - 1);
    localparam logic [TW-1:0] DONE_END = TW'(DONE_TMO_CYC - 1);
    localparam logic [TW-1:0] INIT_END = TW'(INIT_CLKS - 1);

    cfg_state_e state_d;
    fail_code_e err_d;
    logic [TW-1:0] tmr;
    logic byte_last;

    always_comb begin
        state_d = state_q;
        err_d   = err_q;
        load    = 1'b0;
        shift   = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_DONE, ST_ERR: begin
                if (start) begin
                    state_d = ST_REQ;
                    err_d   = FC_NONE;
                end
            end
            ST_REQ: begin
                if (tmr == REQ_END) state_d = ST_WREL;
            end
            ST_WREL: begin
                if (sense.stat_ok) begin
                    state_d = ST_LOAD;
                end else if (tmr == REL_END) begin
                    state_d = ST_ERR;
                    err_d   = FC_REL_TMO;
                end
            end
            ST_LOAD: begin
                if (!sense.stat_ok) begin
                    state_d = ST_ERR;
                    err_d   = FC_STAT;
                end else if (sense.done) begin
                    state_d = ST_INIT;
                end else if (s_valid) begin
                    load    = 1'b1;
                    state_d = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (!sense.stat_ok) begin
                    state_d = ST_ERR;
                    err_d   = FC_STAT;
                end else if (fall_tick) begin
                    if (sense.done)    state_d = ST_INIT;
                    else if (last_bit) state_d = byte_last ? ST_WDONE : ST_LOAD;
                    else               shift   = 1'b1;
                end
            end
            ST_WDONE: begin
                if (!sense.stat_ok) begin
                    state_d = ST_ERR;
                    err_d   = FC_STAT;
                end else if (sense.done) begin
                    state_d = ST_INIT;
                end else if (tmr == DONE_END) begin
                    state_d = ST_ERR;
                    err_d   = FC_DONE_TMO;
                end
            end
            ST_INIT: begin
                if (fall_tick && (tmr == INIT_END)) state_d = ST_DONE;
            end
            default: begin
                state_d = ST_ERR;
                err_d   = FC_STAT;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            err_q     <= FC_NONE;
            byte_last <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= err_d;
            if (load) byte_last <= s_last;
        end
    end

    // One timer serves every state: cycles in the waiting states, data-clock falls in INIT
    always_ff @(posedge clk) begin
        if (rst || (state_d != state_q)) begin
            tmr <= '0;
        end else if (state_q == ST_INIT) begin
            if (fall_tick) tmr <= tmr + 1'b1;
        end else if ((state_q == ST_REQ) || (state_q == ST_WREL) || (state_q == ST_WDONE)) begin
            tmr <= tmr + 1'b1;
        end
    end

    assign run_now  = clk_running(state_q);
    assign run_next = clk_running(state_d);
    assign s_ready  = (state_q == ST_LOAD) && sense.stat_ok && !sense.done;
endmodule

// File: rtl/ps_cfg_host.sv
module ps_cfg_host
    import ps_cfg_pkg::*;
#(
    parameter int unsigned BYTE_W       = 8,
    parameter int unsigned CLK_DIV      = 4,
    parameter int unsigned REQ_LOW_CYC  = 16,
    parameter int unsigned REL_TMO_CYC  = 4096,
    parameter int unsigned DONE_TMO_CYC = 65536,
    parameter int unsigned INIT_CLKS    = 8,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [BYTE_W-1:0] s_data,
    input  logic              s_valid,
    input  logic              s_last,
    output logic              s_ready,
    output logic              cfg_req_n,
    input  logic              stat_n,
    input  logic              done_in,
    output logic              ser_clk,
    output logic              ser_data,
    output logic              busy,
    output logic              cfg_done,
    output logic              cfg_fail,
    output logic [1:0]        fail_code
);
    localparam int unsigned N_SENSE = 2;

    logic [N_SENSE-1:0] raw_sense;
    logic [N_SENSE-1:0] sync_sense;
    tgt_sense_t sense;

    cfg_state_e state;
    fail_code_e err;
    logic run_now, run_next, fall_tick;
    logic load, shift, shreg_bit, last_bit;

    assign raw_sense = {done_in, stat_n};

    for (genvar g = 0; g < N_SENSE; g++) begin : g_sync
        ps_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk (clk),
            .rst (rst),
            .d   (raw_sense[g]),
            .q   (sync_sense[g])
        );
    end

    assign sense.stat_ok = sync_sense[0];
    assign sense.done    = sync_sense[1];

    ps_seq #(
        .REQ_LOW_CYC  (REQ_LOW_CYC),
        .REL_TMO_CYC  (REL_TMO_CYC),
        .DONE_TMO_CYC (DONE_TMO_CYC),
        .INIT_CLKS    (INIT_CLKS)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .sense     (sense),
        .fall_tick (fall_tick),
        .s_valid   (s_valid),
        .s_last    (s_last),
        .last_bit  (last_bit),
        .state_q   (state),
        .run_now   (run_now),
        .run_next  (run_next),
        .load      (load),
        .shift     (shift),
        .s_ready   (s_ready),
        .err_q     (err)
    );

    ps_clkgen #(.DIV(CLK_DIV)) u_clk (
        .clk       (clk),
        .rst       (rst),
        .run_now   (run_now),
        .run_next  (run_next),
        .sclk      (ser_clk),
        .fall_tick (fall_tick)
    );

    ps_shifter #(.W(BYTE_W)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .din    (s_data),
        .shift  (shift),
        .bit_o  (shreg_bit),
        .last_o (last_bit)
    );

    assign ser_data  = (state == ST_SHIFT) && shreg_bit;
    assign cfg_req_n = !holds_reset(state);
    assign busy      = !accepts_start(state);
    assign cfg_done  = (state == ST_DONE);
    assign cfg_fail  = (state == ST_ERR);
    assign fail_code = err;
endmodule

// File: rtl/ps_cfg_host_chk.sv
module ps_cfg_host_chk #(
    parameter int unsigned DIV     = 4,
    parameter int unsigned REQ_LOW = 16
) (
    input logic clk,
    input logic rst,
    input logic start,
    input logic cfg_req_n,
    input logic s_ready,
    input logic ser_clk,
    input logic ser_data,
    input logic cfg_done,
    input logic cfg_fail
);
    localparam int unsigned HALF = DIV / 2;
    localparam int unsigned LW   = $clog2(REQ_LOW + 1);
    localparam int unsigned HW   = $clog2(DIV + 1);

    logic [LW-1:0] low_cnt;
    logic [HW-1:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst || cfg_req_n)            low_cnt <= '0;
        else if (low_cnt != LW'(REQ_LOW)) low_cnt <= low_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || !ser_clk)           hi_cnt <= '0;
        else if (hi_cnt != HW'(DIV))   hi_cnt <= hi_cnt + 1'b1;
    end

    AST_REQ_LOW_MIN: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_req_n) |-> (low_cnt >= LW'(REQ_LOW))); // R2

    AST_QUIET_IN_RESET: assert property (@(posedge clk) disable iff (rst)
        !cfg_req_n |-> (!s_ready && !ser_clk)); // R3

    AST_HIGH_WIDTH: assert property (@(posedge clk) disable iff (rst)
        ($fell(ser_clk) && !cfg_fail) |-> (hi_cnt == HW'(HALF))); // R4

    AST_DATA_STABLE: assert property (@(posedge clk) disable iff (rst)
        $rose(ser_clk) |-> $stable(ser_data)); // R5

    AST_READY_CLK_LOW: assert property (@(posedge clk) disable iff (rst)
        s_ready |-> !ser_clk); // R6

    AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (rst)
        cfg_done |-> (cfg_req_n && !cfg_fail && !ser_clk)); // R7

    AST_FAIL_QUIET: assert property (@(posedge clk) disable iff (rst)
        cfg_fail |-> (!ser_clk && !s_ready && !cfg_req_n)); // R8

    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
        (cfg_fail && !start) |=> cfg_fail); // R10
endmodule

bind ps_cfg_host ps_cfg_host_chk #(
    .DIV     (CLK_DIV),
    .REQ_LOW (REQ_LOW_CYC)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .cfg_req_n (cfg_req_n),
    .s_ready   (s_ready),
    .ser_clk   (ser_clk),
    .ser_data  (ser_data),
    .cfg_done  (cfg_done),
    .cfg_fail  (cfg_fail)
);

// File: tb/tb_ps_cfg_host.sv
`timescale 1ns/1ps
module tb_ps_cfg_host;
    localparam int DIV  = 4;
    localparam int HALF = DIV / 2;
    localparam int RQL  = 6;
    localparam int RELT = 30;
    localparam int DNT  = 40;
    localparam int INC  = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [7:0] s_data = 8'h00;
    logic s_valid = 1'b0;
    logic s_last = 1'b0;
    logic s_ready, cfg_req_n, ser_clk, ser_data, busy, cfg_done, cfg_fail;
    logic stat_n = 1'b0;
    logic done_in = 1'b0;
    logic [1:0] fail_code;

    always #2 clk = ~clk;

    ps_cfg_host #(
        .BYTE_W(8), .CLK_DIV(DIV), .REQ_LOW_CYC(RQL), .REL_TMO_CYC(RELT),
        .DONE_TMO_CYC(DNT), .INIT_CLKS(INC), .SYNC_STAGES(2)
    ) dut (
        .clk(clk), .rst(rst), .start(start), .s_data(s_data), .s_valid(s_valid),
        .s_last(s_last), .s_ready(s_ready), .cfg_req_n(cfg_req_n), .stat_n(stat_n),
        .done_in(done_in), .ser_clk(ser_clk), .ser_data(ser_data), .busy(busy),
        .cfg_done(cfg_done), .cfg_fail(cfg_fail), .fail_code(fail_code)
    );

    int checks = 0;
    int errors = 0;

    // control set by the main sequence
    bit mon_clr = 1'b0;
    bit feed_en = 1'b0;
    int nbytes  = 0;

    // monitor / feeder state
    bit   prev_sclk = 1'b0;
    bit   prev_data = 1'b0;
    int   rises = 0, rx_cnt = 0, rx_nb = 0, gap = 0, hi_w = 0;
    int   bad_width = 0, bad_period = 0, bad_stab = 0, bad_ready = 0, bad_perbyte = 0;
    int   rises_since = 0, idx = 0;
    bit   hs_pend = 1'b0;
    logic [7:0] rx_sh = 8'h00;
    logic [7:0] rx_mem [0:255];

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (mon_clr) begin
            rises = 0; rx_cnt = 0; rx_nb = 0; gap = 0; hi_w = 0;
            bad_width = 0; bad_period = 0; bad_stab = 0; bad_ready = 0; bad_perbyte = 0;
            rises_since = 0; idx = 0; hs_pend = 1'b0;
        end else begin
            gap++;
            if (ser_clk && !prev_sclk) begin
                rises++; rises_since++;
                if (ser_data !== prev_data) bad_stab++;
                if (rx_nb != 0 && gap != DIV) bad_period++;
                gap = 0;
                rx_sh = {ser_data, rx_sh[7:1]};
                rx_nb++;
                if (rx_nb == 8) begin
                    if (rx_cnt < 256) rx_mem[rx_cnt] = rx_sh;
                    rx_cnt++;
                    rx_nb = 0;
                end
            end
            if (ser_clk) hi_w++;
            else begin
                if (prev_sclk && !cfg_fail && hi_w != HALF) bad_width++;
                hi_w = 0;
            end
            if (s_ready && ser_clk) bad_ready++;
            if (hs_pend) begin
                if (idx > 0 && rises_since != 8) bad_perbyte++;
                rises_since = 0;
                idx++;
            end
        end
        prev_sclk = ser_clk;
        prev_data = ser_data;
        s_valid = feed_en && (idx < nbytes);
        s_data  = pat(idx);
        s_last  = (idx == nbytes - 1);
        hs_pend = s_valid && s_ready;
    end

    task automatic clear_mon();
        mon_clr = 1'b1;
        repeat (2) @(negedge clk);
        mon_clr = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    // start a load; returns cycles the request line stayed low
    task automatic begin_load(output int lowc);
        feed_en = 1'b0; stat_n = 1'b0; done_in = 1'b0;
        clear_mon();
        pulse_start();
        lowc = 0;
        while (!cfg_req_n && lowc < 200) begin lowc++; @(negedge clk); end
    endtask

    task automatic release_stat(output int viol);
        viol = 0;
        for (int k = 0; k < 5; k++) begin
            if (s_ready || ser_clk) viol++;
            @(negedge clk);
        end
        stat_n = 1'b1;
    endtask

    task automatic wait_rx(input int n);
        for (int k = 0; k < 60000 && rx_cnt < n; k++) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int lowc, viol, n, r0, acc;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!cfg_req_n && !ser_clk && !s_ready && !busy && !cfg_done && !cfg_fail && fail_code == 0,
            "R1 reset outputs", {cfg_req_n, ser_clk, s_ready, busy, cfg_done, cfg_fail}, 0);

        // ---- main load: 256 byte sweep ----
        nbytes = 256;
        begin_load(lowc);
        chk(lowc == RQL, "R2 request low width", lowc, RQL);
        release_stat(viol);
        chk(viol == 0, "R3 no data before status release", viol, 0);
        feed_en = 1'b1;
        wait_rx(100);
        pulse_start();  // R11: must be ignored mid-load
        repeat (6) @(negedge clk);
        chk(cfg_req_n && busy, "R11 start ignored while busy", cfg_req_n, 1);
        wait_rx(256);
        repeat (8) @(negedge clk);
        done_in = 1'b1;
        for (int k = 0; k < 200 && !cfg_done; k++) @(negedge clk);
        chk(cfg_done && !cfg_fail, "R7 done flag", cfg_done, 1);
        n = 0;
        for (int i = 0; i < 256; i++) if (rx_mem[i] !== pat(i)) n++;
        chk(n == 0 && rx_cnt == 256, "R5 R11 LSB-first byte sweep intact", n, 0);
        chk(rises - 256 * 8 == INC, "R7 extra init clocks", rises - 2048, INC);
        chk(bad_width == 0, "R4 high width", bad_width, 0);
        chk(bad_period == 0, "R4 period", bad_period, 0);
        chk(bad_stab == 0, "R5 data stable at rising edge", bad_stab, 0);
        chk(bad_ready == 0 && bad_perbyte == 0, "R6 ready and 8 clocks per byte", bad_perbyte, 0);
        chk(cfg_req_n && !ser_clk && !s_ready, "R7 request stays high after done", cfg_req_n, 1);

        // ---- status drop mid-stream ----
        nbytes = 50;
        begin_load(lowc);
        chk(lowc == RQL, "R2 R10 restart from done", lowc, RQL);
        release_stat(viol);
        feed_en = 1'b1;
        wait_rx(5);
        stat_n = 1'b0;
        n = 0;
        @(negedge clk);
        while (!cfg_fail && n < 20) begin n++; @(negedge clk); end
        chk(n == 2, "R8 status error latency", n + 1, 3);
        chk(fail_code == 1 && !ser_clk && !s_ready && !cfg_req_n, "R8 failed state outputs", fail_code, 1);
        r0 = rises;
        repeat (50) @(negedge clk);
        chk(cfg_fail && rises == r0, "R10 no automatic restart", rises - r0, 0);

        // ---- collision: status drop and done rise together ----
        begin_load(lowc);
        chk(lowc == RQL, "R10 restart from failure", lowc, RQL);
        release_stat(viol);
        feed_en = 1'b1;
        wait_rx(3);
        stat_n = 1'b0; done_in = 1'b1;
        repeat (10) @(negedge clk);
        chk(cfg_fail && !cfg_done && fail_code == 1, "R8 status wins over done", fail_code, 1);

        // ---- done timeout ----
        nbytes = 3;
        begin_load(lowc);
        release_stat(viol);
        feed_en = 1'b1;
        wait_rx(3);
        for (int k = 0; k < 20 && ser_clk; k++) @(negedge clk);
        n = 0;
        while (!cfg_fail && n < 500) begin n++; @(negedge clk); end
        chk(n == DNT, "R9 done timeout cycles", n, DNT);
        chk(fail_code == 2, "R9 done timeout code", fail_code, 2);

        // ---- status never released ----
        feed_en = 1'b0; stat_n = 1'b0; done_in = 1'b0;
        clear_mon();
        pulse_start();
        for (int k = 0; k < 50 && !cfg_req_n; k++) @(negedge clk);
        n = 0;
        while (!cfg_fail && n < 500) begin
            if (ser_clk || s_ready) viol++;
            n++; @(negedge clk);
        end
        chk(n == RELT, "R3 release timeout cycles", n, RELT);
        chk(fail_code == 3 && !cfg_req_n, "R3 release timeout code", fail_code, 3);

        // ---- done before end of stream ----
        nbytes = 20;
        begin_load(lowc);
        release_stat(viol);
        feed_en = 1'b1;
        wait_rx(2);
        done_in = 1'b1;
        for (int k = 0; k < 300 && !cfg_done; k++) @(negedge clk);
        acc = idx;
        chk(cfg_done && !cfg_fail && acc < 20, "R7 early done stops stream", acc, 3);
        repeat (20) @(negedge clk);
        chk(idx == acc && !s_ready, "R7 no bytes taken after done", idx, acc);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule